// File: doc/BRIEF.md
# In-band end-of-packet escape encoder

This block turns a 64-bit valid/ready stream that carries a packet-end flag into a 64-bit stream that has no such flag. The packet boundary travels inside the data instead. A reserved escape word, 0xDEADBEEFFEEDCAFE, starts a three-word sequence: the escape word, then a flag word, then the original data word. The low half of the flag word says whether that data word ends a packet. The block writes such a sequence for every packet-final word. It also writes one for every data word that happens to equal the escape word, so that a decoder can always tell a real escape from a literal one. Every other word passes straight through with no added latency.

An optional 32-bit XOR checksum can ride in the upper half of the flag word of a packet-final sequence. The running value folds in each word that leaves while the block is outside a sequence. Folding a word means XOR-ing its two 32-bit halves into the running value. The input word is held in place, with the input ready signal low, while its escape and flag words go out. The word is accepted only on the cycle its own copy is transferred. An active-low synchronous reset and a synchronous clear both return the block to pass-through and zero the checksum.

Top module: `esc_last_encoder`

## Requirements
- R1: An input word that is not packet-final and differs from 0xDEADBEEFFEEDCAFE leaves as one unchanged output word in the same cycle, with input ready equal to output ready.
- R2: A packet-final input word that differs from the escape word is emitted as the escape word, then a flag word with bits [31:0] equal to 1, then the original word.
- R3: An input word equal to the escape word that is not packet-final is emitted as the escape word, then a flag word with bits [31:0] equal to 0 and bits [63:32] equal to 0, then the escape word.
- R4: An input word equal to the escape word that is packet-final is emitted as the escape word, then a flag word with bits [31:0] equal to 1, then the escape word.
- R5: While the escape word or the flag word of a sequence is on the output, input ready is low. An input word is accepted only in the cycle its own copy is transferred downstream.
- R6: Once output valid is high and output ready is low, output valid stays high and output data stays unchanged in the next cycle.
- R7: With checksum insertion enabled, bits [63:32] of a packet-final flag word hold the XOR of the folds (low half XOR high half) of every word emitted outside a sequence since the previous packet end, reset or clear. The escape word of the current sequence is excluded. The running value returns to zero once the packet-final word is accepted.
- R8: With checksum insertion disabled, bits [63:32] of every flag word are zero, and the rest of the output stream is unchanged.
- R9: A low rst_n returns the block to pass-through with a zero checksum, even in the middle of a sequence. A word still offered afterwards is encoded again from its escape word.
- R10: A high clr has the same effect as reset, including in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear, active high |
| s_data | input | DATA_W | Input data word |
| s_last | input | 1 | Input word ends a packet |
| s_valid | input | 1 | Input word offered |
| s_ready | output | 1 | Input word accepted when high with s_valid |
| m_data | output | DATA_W | Output data word |
| m_valid | output | 1 | Output word offered |
| m_ready | input | 1 | Downstream accepts output word |

## Verification
The hardest case to reach is a downstream stall that lands on the escape or flag word of a packet-final sequence, while the same input word must stay held and the checksum snapshot must not move. A reset or clear that arrives inside a sequence is just as hard to reach. A table of words that mixes literal escape values, near-miss values and single-word packets is walked twice: once with output ready always high, and once with random output stalls and random input gaps. Directed tests then drop a reset on a flag word and a clear on a held data word, and check that the word is encoded again with a zero checksum. A second instance with the checksum disabled runs in lockstep to cover the zeroed flag upper half.

// File: rtl/esc_enc_pkg.sv
`timescale 1ns/1ps
// Shared types for the escape encoder.
// Assumes: nothing beyond IEEE 1800-2017.
package esc_enc_pkg;
    typedef enum logic [1:0] {
        ST_PASS = 2'd0,   // pass-through, or escape word on output
        ST_FLAG = 2'd1,   // flag word on output
        ST_DATA = 2'd2    // held word's own copy on output
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_IN   = 2'd0,
        SEL_ESC  = 2'd1,
        SEL_FLAG = 2'd2
    } word_sel_e;
endpackage

// File: rtl/esc_match.sv
`timescale 1ns/1ps
// Compares a word against the escape constant lane by lane.
// Assumes: DATA_W is a multiple of LANE_W.
module esc_match #(
    parameter int          DATA_W   = 64,
    parameter int          LANE_W   = 16,
    parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE
) (
    input  logic [DATA_W-1:0] word,
    output logic              hit
);
    localparam int NLANE = DATA_W / LANE_W;

    logic [NLANE-1:0] lane_eq;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        // per-lane equality
        assign lane_eq[g] = (word[g*LANE_W +: LANE_W] == ESC_WORD[g*LANE_W +: LANE_W]);
    end

    // all lanes equal
    assign hit = &lane_eq;
endmodule

// File: rtl/esc_seq_fsm.sv
`timescale 1ns/1ps
// Sequencer: chooses which word is on the output and when the input
// word is consumed. Holds the input word (s_ready low) during the
// escape and flag words.
// Assumes: the upstream keeps s_valid, s_data and s_last stable until accepted.
module esc_seq_fsm
    import esc_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       s_valid,
    input  logic       s_last,
    input  logic       need_esc,
    input  logic       m_ready,
    output seq_state_e state,
    output word_sel_e  sel,
    output logic       s_ready,
    output logic       m_valid,
    output logic       fold_en,
    output logic       pkt_done
);
    seq_state_e nxt;

    // state register with reset and clear
    always_ff @(posedge clk) begin
        if (!rst_n || clr) state <= ST_PASS;
        else               state <= nxt;
    end

    // output select, handshakes and next state
    always_comb begin
        nxt      = state;
        sel      = SEL_IN;
        s_ready  = 1'b0;
        m_valid  = 1'b0;
        fold_en  = 1'b0;
        pkt_done = 1'b0;
        unique case (state)
            ST_PASS: begin
                if (s_valid && need_esc) begin
                    sel     = SEL_ESC;
                    m_valid = 1'b1;
                    fold_en = m_ready;
                    if (m_ready) nxt = ST_FLAG;
                end else begin
                    m_valid = s_valid;
                    s_ready = m_ready;
                    fold_en = s_valid && m_ready;
                end
            end
            ST_FLAG: begin
                sel     = SEL_FLAG;
                m_valid = 1'b1;
                if (m_ready) nxt = ST_DATA;
            end
            ST_DATA: begin
                m_valid = s_valid;
                s_ready = m_ready;
                if (s_valid && m_ready) begin
                    nxt      = ST_PASS;
                    pkt_done = s_last;
                end
            end
            default: nxt = ST_PASS;
        endcase
    end

    // R2
    escape_to_flag_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_PASS && sel == SEL_ESC && m_ready) |=> (state == ST_FLAG));

    // R2
    flag_to_data_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_FLAG && m_ready) |=> (state == ST_DATA));
endmodule

// File: rtl/esc_csum.sv
`timescale 1ns/1ps
// Running XOR checksum over words emitted outside a sequence; keeps a
// snapshot taken just before each escape word is folded in.
// Assumes: fold_en and pkt_done never coincide.
module esc_csum #(
    parameter int DATA_W  = 64,
    parameter bit CSUM_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              fold_en,
    input  logic [DATA_W-1:0] fold_word,
    input  logic              pkt_done,
    input  logic              last,
    output logic [DATA_W/2-1:0] field
);
    localparam int HALF_W = DATA_W / 2;

    logic [HALF_W-1:0] run;
    logic [HALF_W-1:0] snap;

    // accumulate folds, snapshot before each fold, zero at packet end
    always_ff @(posedge clk) begin
        if (!rst_n || clr || pkt_done) begin
            run  <= '0;
            snap <= '0;
        end else if (fold_en) begin
            snap <= run;
            run  <= run ^ fold_word[HALF_W-1:0] ^ fold_word[DATA_W-1:HALF_W];
        end
    end

    // checksum only on packet-final flag words, and only if enabled
    assign field = (CSUM_EN && last) ? snap : '0;

    // R7
    csum_zero_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        pkt_done |=> (run == '0));
endmodule

// File: rtl/esc_last_encoder.sv
`timescale 1ns/1ps
// Encodes the packet-end flag in-band: a packet-final word or a literal
// escape word becomes escape, flag, data. Other words pass through
// combinationally.
// Assumes: valid/ready protocol upstream (held until accepted).
module esc_last_encoder
    import esc_enc_pkg::*;
#(
    parameter int                DATA_W   = 64,
    parameter logic [DATA_W-1:0] ESC_WORD = 64'hDEADBEEFFEEDCAFE,
    parameter bit                CSUM_EN  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    input  logic              s_valid,
    output logic              s_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_valid,
    input  logic              m_ready
);
    localparam int HALF_W = DATA_W / 2;

    logic              is_esc;
    logic              need_esc;
    seq_state_e        state;
    word_sel_e         sel;
    logic              fold_en;
    logic              pkt_done;
    logic [HALF_W-1:0] csum_field;
    logic [DATA_W-1:0] flag_word;

    esc_match #(.DATA_W(DATA_W), .LANE_W(16), .ESC_WORD(ESC_WORD)) i_match (
        .word (s_data),
        .hit  (is_esc)
    );

    assign need_esc = s_last || is_esc;

    esc_seq_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .s_valid  (s_valid),
        .s_last   (s_last),
        .need_esc (need_esc),
        .m_ready  (m_ready),
        .state    (state),
        .sel      (sel),
        .s_ready  (s_ready),
        .m_valid  (m_valid),
        .fold_en  (fold_en),
        .pkt_done (pkt_done)
    );

    esc_csum #(.DATA_W(DATA_W), .CSUM_EN(CSUM_EN)) i_csum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .fold_en   (fold_en),
        .fold_word (m_data),
        .pkt_done  (pkt_done),
        .last      (s_last),
        .field     (csum_field)
    );

    // flag word: checksum high, end marker low
    assign flag_word = {csum_field, {(HALF_W-1){1'b0}}, s_last};

    // output word mux
    always_comb begin
        unique case (sel)
            SEL_ESC:  m_data = ESC_WORD;
            SEL_FLAG: m_data = flag_word;
            default:  m_data = s_data;
        endcase
    end

    // R1
    plain_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_PASS && s_valid && !s_last && s_data != ESC_WORD)
        |-> (m_valid && m_data == s_data && s_ready == m_ready));

    // R5
    accept_with_copy_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (s_valid && s_ready) |-> (m_valid && m_ready && m_data == s_data));

    // R6
    seq_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (m_valid && !m_ready && sel != SEL_IN) |=> (m_valid && $stable(m_data)));
endmodule

// File: tb/test_esc_last_encoder.sv
`timescale 1ns/1ps
module test_esc_last_encoder;
    localparam logic [63:0] ESC = 64'hDEADBEEFFEEDCAFE;

    typedef struct {
        logic [63:0] w;
        string       req;
        bit          held;
        bit          flag;
    } exp_t;

    // {last, data}
    localparam logic [64:0] VEC [16] = '{
        {1'b0, 64'h0000000000000011},
        {1'b0, ESC},
        {1'b1, 64'h1234567887654321},
        {1'b0, 64'h0000000000000005},
        {1'b1, ESC},
        {1'b0, 64'hFFFF0000FFFF0000},
        {1'b0, 64'hAAAA5555AAAA5555},
        {1'b1, 64'h0123456789ABCDEF},
        {1'b1, 64'h0000000000000001},
        {1'b0, ESC},
        {1'b0, ESC},
        {1'b0, 64'hDEADBEEF00000000},
        {1'b1, 64'h00000000FEEDCAFE},
        {1'b0, 64'h1111111111111111},
        {1'b0, 64'h2222222222222222},
        {1'b1, 64'h3333333333333333}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [63:0] s_data = '0;
    logic        s_last = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [63:0] m_data;
    logic        m_valid;
    logic        m_ready = 1'b0;
    logic        pl_ready;
    logic [63:0] pl_data;
    logic        pl_valid;

    int    checks = 0;
    int    fails = 0;
    exp_t  q[$];
    logic [31:0] run = '0;
    bit    rnd = 1'b0;
    bit    prev_stall = 1'b0;
    logic [63:0] prev_data = '0;

    always #2.5 clk = ~clk;

    esc_last_encoder i_esc_last_encoder (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .s_data(s_data), .s_last(s_last), .s_valid(s_valid), .s_ready(s_ready),
        .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready)
    );

    esc_last_encoder #(.CSUM_EN(1'b0)) i_esc_last_encoder_plain (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .s_data(s_data), .s_last(s_last), .s_valid(s_valid), .s_ready(pl_ready),
        .m_data(pl_data), .m_valid(pl_valid), .m_ready(m_ready)
    );

    function automatic logic [31:0] fold(input logic [63:0] w);
        return w[31:0] ^ w[63:32];
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // reference model: expected output words for one input word
    task automatic enqueue(input logic [63:0] w, input bit last);
        if (last || w == ESC) begin
            string r = (w == ESC) ? (last ? "R4" : "R3") : "R2";
            q.push_back('{ESC, r, 1'b1, 1'b0});
            q.push_back('{{(last ? run : 32'h0), 31'h0, last}, last ? "R7" : "R3", 1'b1, 1'b1});
            run = run ^ fold(ESC);
            q.push_back('{w, r, 1'b0, 1'b0});
            if (last) run = '0;
        end else begin
            q.push_back('{w, "R1", 1'b0, 1'b0});
            run = run ^ fold(w);
        end
    endtask

    task automatic observe();
        if (prev_stall)
            check(m_valid && m_data == prev_data, "R6", m_data, prev_data);
        if (q.size() > 0 && q[0].held && s_valid)
            check(!s_ready, "R5", {63'h0, s_ready}, 64'h0);
        if (m_valid && m_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R1", m_data, 64'h0);
            end else begin
                exp_t e = q.pop_front();
                check(m_data == e.w, e.req, m_data, e.w);
                if (e.flag)
                    check(pl_valid && pl_data == {32'h0, e.w[31:0]}, "R8", pl_data, {32'h0, e.w[31:0]});
            end
        end
        prev_stall = m_valid && !m_ready;
        prev_data  = m_data;
    endtask

    task automatic step();
        m_ready = rnd ? ($urandom_range(0, 2) != 0) : 1'b1;
        #1;
        observe();
    endtask

    task automatic wait_accept(input logic [63:0] w, input bit last);
        bit acc = 1'b0;
        while (!acc) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = w; s_last = last;
            step();
            acc = s_valid && s_ready;
        end
    endtask

    task automatic send(input logic [63:0] w, input bit last);
        enqueue(w, last);
        if (rnd) begin
            for (int g = $urandom_range(0, 1); g > 0; g--) begin
                @(negedge clk);
                s_valid = 1'b0;
                step();
            end
        end
        wait_accept(w, last);
    endtask

    task automatic drain();
        for (int k = 0; k < 200 && q.size() > 0; k++) begin
            @(negedge clk);
            s_valid = 1'b0;
            step();
        end
        check(q.size() == 0, "R2", 64'(q.size()), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: state right after reset
        rst_n = 1'b1;
        m_ready = 1'b1;
        #1;
        check(!m_valid, "R9", {63'h0, m_valid}, 64'h0);
        check(s_ready, "R9", {63'h0, s_ready}, 64'h1);

        // table walk: pass 0 with ready held high, pass 1 with random stalls
        for (int p = 0; p < 2; p++) begin
            rnd = (p == 1);
            for (int i = 0; i < 16; i++) send(VEC[i][63:0], VEC[i][64]);
        end
        drain();
        rnd = 1'b0;

        // R9: reset while the flag word is pending
        send(64'h0F0F0F0F0F0F0F0F, 1'b0);
        drain();
        enqueue(64'h4444444444444444, 1'b1);
        @(negedge clk);
        s_valid = 1'b1; s_data = 64'h4444444444444444; s_last = 1'b1;
        step();
        @(negedge clk);
        rst_n = 1'b0; m_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        q.delete(); run = '0; prev_stall = 1'b0;
        enqueue(64'h4444444444444444, 1'b1);
        wait_accept(64'h4444444444444444, 1'b1);
        drain();

        // R10: clear while the held data word is pending
        send(64'h00FF00FF12345678, 1'b0);
        enqueue(64'h5555555555555555, 1'b1);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            s_valid = 1'b1; s_data = 64'h5555555555555555; s_last = 1'b1;
            step();
        end
        @(negedge clk);
        clr = 1'b1; m_ready = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        q.delete(); run = '0; prev_stall = 1'b0;
        enqueue(64'h5555555555555555, 1'b1);
        wait_accept(64'h5555555555555555, 1'b1);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got %h expected %h", 64'h0, 64'h1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule